// File: doc/BRIEF.md
# Filtered Edge-Event GPIO Port

This block is an eight-pin general-purpose port. Each pin can be an input or an output, and each pin can raise an interrupt on an edge. The software side reaches every register through a small synchronous write bus and a combinational read path. On the pad side there is one input level, one output level and one output enable per pin. The pad input always carries the true level on the pin, so a pin set as an output still sees its own transitions.

Every pin level passes through a two-flop synchronizer and then through a per-pin qualification counter. A pin counts as active when its level matches the polarity chosen for it: high for rising, low for falling. A pin first has to be seen inactive, which arms it. It must then stay active for N consecutive cycles, where N comes from a shared filter register. When that happens, one event sets the pin's sticky flag. Any shorter excursion is discarded.

The enabled flags are ORed into a single interrupt request. A wake output adds an unclocked path from the pads, so a low-power controller can be woken while the clock is gated.

Top module: `pin_event_port`

## Requirements
- R1: After reset, pad_oe and pad_out are all zero, every flag is clear, irq_o is low, the filter register reads 2 and the polarity register reads 0.
- R2: Registers sit at these bus_addr values: 0 output data, 1 direction (1 = output), 2 interrupt enable, 3 polarity (1 = rising, 0 = falling), 4 flags, 5 filter count N, 6 synchronized pin levels (read only). Registers 0, 1, 2, 3 and 5 read back what was written, and address 7 reads 0.
- R3: pad_oe equals the direction register and pad_out equals the output data register.
- R4: On a rising-polarity pin, a high pulse of at least N cycles sets the pin's flag. Counting from the cycle in which pad_in changes, the flag is visible after clock edge N+2 and not after edge N+1.
- R5: On a falling-polarity pin, a low pulse of at least N cycles sets the pin's flag.
- R6: A pulse at the active level shorter than N cycles sets no flag.
- R7: A filter count of 0 behaves like a count of 1.
- R8: Edges are detected on a pin set as an output, where the pad input follows the pin's own driven level.
- R9: irq_o is the OR over all pins of flag AND enable. A flag is set whether or not its enable bit is set.
- R10: Writing 1 to a flag bit clears that flag. Writing 0 leaves the flag unchanged.
- R11: If a qualified event and a clear of the same flag land on the same clock edge, the flag stays set.
- R12: wake_o rises without any clock edge when an enabled, armed pin reaches its active level. It is also high whenever irq_o is high.
- R13: A pin held at its active level produces only one event. A new event needs the pin to go inactive and then active again.
- R14: A pin that is already at its active level when reset is released sets no flag until it has been seen inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 8 | Pad levels |
| pad_out | output | 8 | Output levels to the pads |
| pad_oe | output | 8 | Output enables to the pads |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wake request for a low-power controller |

## Verification
Assume a pad change is applied just after a falling clock edge. The synchronizer then takes two edges, and qualification takes N more, so the flag and irq_o change right after edge N+2. The bench counts falling edges and reads on both sides of that edge. Register writes and flag clears take effect at the next rising edge, while reads and wake_o are combinational. All inputs therefore change at falling edges and are sampled one nanosecond later. For the wake path, the check is made before any rising edge has occurred. For the same-edge clear, the write strobe is timed to coincide with edge N+2.

// File: rtl/pep_pkg.sv
package pep_pkg;
    typedef enum logic [2:0] {
        ADDR_DOUT = 3'd0,
        ADDR_DIR  = 3'd1,
        ADDR_IEN  = 3'd2,
        ADDR_POL  = 3'd3,
        ADDR_FLAG = 3'd4,
        ADDR_FILT = 3'd5,
        ADDR_PIN  = 3'd6
    } pep_addr_e;

    localparam int unsigned FILT_RESET = 2;
endpackage

// File: rtl/pep_sync.sv
module pep_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/pep_filter.sv
module pep_filter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_i,
    input  logic             rising_i,
    input  logic             disarm_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             qual_o,
    output logic             armed_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } filt_t;

    filt_t st_d, st_q;
    logic  active;
    logic  [CNT_W-1:0] last_cnt;

    always_comb begin
        active   = rising_i ? level_i : ~level_i;
        last_cnt = (limit_i == '0) ? '0 : limit_i - 1'b1;
        st_d     = st_q;
        qual_o   = 1'b0;
        if (disarm_i) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (!active) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (st_q.armed) begin
            if (st_q.cnt == last_cnt) begin
                qual_o     = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;

    // One event per active run: a qualification cannot repeat on the next cycle
    assert_single_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |=> !qual_o);
endmodule

// File: rtl/pin_event_port.sv
module pin_event_port #(
    parameter int unsigned NPIN  = 8,
    parameter int unsigned CNT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic            irq_o,
    output logic            wake_o
);
    import pep_pkg::*;

    typedef struct packed {
        logic [NPIN-1:0]  dout;
        logic [NPIN-1:0]  dir;
        logic [NPIN-1:0]  ien;
        logic [NPIN-1:0]  pol;
        logic [NPIN-1:0]  flag;
        logic [CNT_W-1:0] filt;
    } regs_t;

    regs_t           rg_d, rg_q;
    logic [NPIN-1:0] lvl_sync;
    logic [NPIN-1:0] evt;
    logic [NPIN-1:0] armed;
    logic [NPIN-1:0] disarm;
    logic [NPIN-1:0] clr;
    logic [NPIN-1:0] raw_active;
    pep_addr_e       addr;

    assign addr = pep_addr_e'(bus_addr);

    pep_sync #(.WIDTH(NPIN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (lvl_sync)
    );

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            pep_filter #(.CNT_W(CNT_W)) u_filt (
                .clk      (clk),
                .rst_n    (rst_n),
                .level_i  (lvl_sync[i]),
                .rising_i (rg_q.pol[i]),
                .disarm_i (disarm[i]),
                .limit_i  (rg_q.filt),
                .qual_o   (evt[i]),
                .armed_o  (armed[i])
            );
        end
    endgenerate

    always_comb begin
        rg_d   = rg_q;
        clr    = '0;
        disarm = '0;
        if (bus_wr) begin
            case (addr)
                ADDR_DOUT: rg_d.dout = bus_wdata;
                ADDR_DIR:  rg_d.dir  = bus_wdata;
                ADDR_IEN:  rg_d.ien  = bus_wdata;
                ADDR_POL: begin
                    rg_d.pol = bus_wdata;
                    disarm   = bus_wdata ^ rg_q.pol;
                end
                ADDR_FLAG: clr = bus_wdata;
                ADDR_FILT: rg_d.filt = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        rg_d.flag = (rg_q.flag & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q      <= '0;
            rg_q.filt <= CNT_W'(FILT_RESET);
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (addr)
            ADDR_DOUT: bus_rdata = rg_q.dout;
            ADDR_DIR:  bus_rdata = rg_q.dir;
            ADDR_IEN:  bus_rdata = rg_q.ien;
            ADDR_POL:  bus_rdata = rg_q.pol;
            ADDR_FLAG: bus_rdata = rg_q.flag;
            ADDR_FILT: bus_rdata[CNT_W-1:0] = rg_q.filt;
            ADDR_PIN:  bus_rdata = lvl_sync;
            default:   bus_rdata = '0;
        endcase
    end

    assign pad_out    = rg_q.dout;
    assign pad_oe     = rg_q.dir;
    assign irq_o      = |(rg_q.flag & rg_q.ien);
    assign raw_active = ~(pad_in ^ rg_q.pol);
    assign wake_o     = irq_o | (|(rg_q.ien & armed & raw_active));

    // Flags only rise from a qualified event on the previous edge
    assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((rg_q.flag & ~$past(rg_q.flag) & ~$past(evt)) == '0));

    // A write of ones to the flag register clears those flags (no event pending)
    assert_w1c_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && addr == ADDR_FLAG) |=> ((rg_q.flag & $past(bus_wdata & ~evt)) == '0));

    // A qualified event wins over a clear on the same edge
    assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((rg_q.flag & $past(evt)) == $past(evt)));

    // No enabled pin means no interrupt request
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.ien == '0) |-> !irq_o);

    // Wake covers every pending interrupt
    assert_wake_covers_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o);
endmodule

// File: tb/pin_event_port_test.sv
module pin_event_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic       irq_o;
    logic       wake_o;
    logic [7:0] drv = 8'h00;
    int         checks = 0;
    int         fails = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & drv);

    pin_event_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic [7:0] exp_flag(input int w, input int n, input int p);
        int eff = (n == 0) ? 1 : n;
        return (w >= eff) ? (8'h01 << p) : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pol: per-pin polarity; idle levels are the inactive ones
    task automatic setup(input logic [7:0] pol, input logic [7:0] n, input logic [7:0] ien);
        wr(3'd3, pol);
        drv = ~pol;
        wr(3'd5, n);
        wr(3'd2, ien);
        idle(5);
        wr(3'd4, 8'hFF);
    endtask

    task automatic pulse(input int p, input int w);
        @(negedge clk);
        drv[p] = ~drv[p];
        repeat (w) @(negedge clk);
        drv[p] = ~drv[p];
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=done");
        checks++; fails++;
        finish_run();
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // drv low and polarity falling: every pin active at release (R14)
        idle(10);
        rd(3'd4, rv); chk("R14 active at reset release", rv, 8'h00);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        rd(3'd5, rv); chk("R1 filter reset", rv, 8'h02);
        rd(3'd3, rv); chk("R1 polarity reset", rv, 8'h00);

        // R2 readback
        wr(3'd2, 8'h5A); rd(3'd2, rv); chk("R2 enable readback", rv, 8'h5A);
        wr(3'd5, 8'h07); rd(3'd5, rv); chk("R2 filter readback", rv, 8'h07);
        rd(3'd7, rv); chk("R2 unused address", rv, 8'h00);
        drv = 8'hA5; idle(3); rd(3'd6, rv); chk("R2 pin levels", rv, 8'hA5);

        // R3
        wr(3'd0, 8'h3C); wr(3'd1, 8'hC3);
        chk("R3 pad_out", pad_out, 8'h3C);
        chk("R3 pad_oe", pad_oe, 8'hC3);
        rd(3'd0, rv); chk("R2 data readback", rv, 8'h3C);
        rd(3'd1, rv); chk("R2 direction readback", rv, 8'hC3);
        wr(3'd1, 8'h00); wr(3'd0, 8'h00);

        // R4 exact timing, N=3, rising on pin 0, enable off (R9 flag still sets)
        setup(8'hFF, 8'd3, 8'h00);
        @(negedge clk); drv[0] = 1'b1;
        idle(4); rd(3'd4, rv); chk("R4 flag before edge N+2", rv, 8'h00);
        idle(1); rd(3'd4, rv); chk("R4 flag after edge N+2", rv, 8'h01);
        chk("R9 no irq with enable off", {7'd0, irq_o}, 8'h00);
        wr(3'd2, 8'h01); chk("R9 irq once enabled", {7'd0, irq_o}, 8'h01);
        chk("R12 wake follows irq", {7'd0, wake_o}, 8'h01);

        // R13 held level gives one event
        wr(3'd4, 8'h01); idle(12);
        rd(3'd4, rv); chk("R13 no repeat while held", rv, 8'h00);
        drv[0] = 1'b0; idle(4);
        pulse(0, 5); idle(6);
        rd(3'd4, rv); chk("R13 new event after release", rv, 8'h01);

        // R10 write zero keeps flag, write one clears
        wr(3'd4, 8'h00); rd(3'd4, rv); chk("R10 write zero no effect", rv, 8'h01);
        wr(3'd4, 8'h01); rd(3'd4, rv); chk("R10 write one clears", rv, 8'h00);

        // R6 boundary and R5 falling
        setup(8'h00, 8'd4, 8'h00);
        pulse(2, 3); idle(8); rd(3'd4, rv); chk("R6 falling pulse N-1", rv, 8'h00);
        pulse(2, 4); idle(8); rd(3'd4, rv); chk("R5 falling pulse N", rv, 8'h04);

        // R7 N=0 acts as 1
        setup(8'hFF, 8'd0, 8'h00);
        pulse(5, 1); idle(6); rd(3'd4, rv); chk("R7 zero count one-cycle pulse", rv, 8'h20);

        // R8 output pin sees its own edge
        setup(8'hFF, 8'd2, 8'h00);
        wr(3'd1, 8'h08); idle(4); wr(3'd4, 8'hFF);
        wr(3'd0, 8'h08); idle(6);
        rd(3'd4, rv); chk("R8 output pin edge", rv, 8'h08);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);

        // R11 event and clear on the same edge, N=1, pin 0
        setup(8'hFF, 8'd1, 8'h00);
        pulse(0, 4); idle(6); // flag set first
        @(negedge clk); drv[0] = 1'b0; idle(3);
        @(negedge clk); drv[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_addr = 3'd4; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(3'd4, rv); chk("R11 event beats clear", rv, 8'h01);
        drv[0] = 1'b0;

        // R12 wake without a clock edge
        setup(8'hFF, 8'd4, 8'h02);
        @(negedge clk); drv[1] = 1'b1; #1;
        chk("R12 wake before any edge", {7'd0, wake_o}, 8'h01);
        chk("R12 irq not yet", {7'd0, irq_o}, 8'h00);
        drv[1] = 1'b0;
        setup(8'hFF, 8'd4, 8'h00);
        @(negedge clk); drv[1] = 1'b1; #1;
        chk("R12 no wake when disabled", {7'd0, wake_o}, 8'h00);
        drv[1] = 1'b0;

        // Random pulses checked against expected flag and irq
        for (int it = 0; it < 40; it++) begin
            int p = $urandom % 8;
            int w = 1 + ($urandom % 8);
            int n = $urandom % 7;
            logic [7:0] pol = 8'($urandom);
            logic [7:0] ien = 8'($urandom);
            logic [7:0] ef;
            setup(pol, 8'(n), ien);
            pulse(p, w);
            idle(n + 6);
            ef = exp_flag(w, n, p);
            rd(3'd4, rv);
            chk(pol[p] ? "R4 random rising pulse" : "R5 random falling pulse", rv, ef);
            chk("R9 random irq", {7'd0, irq_o}, {7'd0, |(ef & ien)});
        end

        finish_run();
    end
endmodule